// File: doc/BRIEF.md
# Packet Release Watermark Delayer

This block sits on the last step of a packet transmit path, between the logic that assembles a packet and the network controller that sends it. Whenever the assembler signals that a packet is ready to be finalized, the block decides when to let the finalize strobe through. It releases the strobe either at once or after a delay that depends on the next bits of a secret codeword. A receiver that timestamps the packets can therefore read the codeword back from the gaps between packets, and no packet content carries it.

The codeword sits in a circular store with a runtime length. After the last bit it starts again from the first bit, so the mark repeats for as long as traffic flows. In single-bit signalling each packet carries one bit: a one stretches the release by the unit delay and a zero does not. In run signalling, a run of consecutive ones goes out in one packet, delayed by the run length times the unit delay. A configurable cap limits the run length. A unit delay of zero turns marking off. Delays are exact to the clock cycle, down to one or two cycles.

Top module: `pkt_release_marker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `fin_pulse` is 0. After reset the codeword is all zeros, its length is 1 and the bit index is 0.
- R2: With `win_mode`=0 and `unit_dly`=D>0, a request accepted at clock edge k reads codeword bit `idx` (bit 0 is sent first). `fin_pulse` is high in the cycle after edge k+D when that bit is 1, and in the cycle after edge k when it is 0. Delays of 1, 2 and 3 cycles are exact.
- R3: Each accepted request with `unit_dly`>0 advances the bit index by the number of bits that packet signals, modulo the codeword length n, so the codeword wraps and repeats.
- R4: With `win_mode`=1 and D>0, a 0 at the index signals one bit with no delay. A 1 starts a run of consecutive ones, read circularly. The run is capped at `max_run` (a value of 0 acts as 1) and at n. The packet signals that many bits and is delayed by run×D cycles.
- R5: With `unit_dly`=0, every accepted request gives `fin_pulse` in the cycle after the accept edge and leaves the bit index unchanged.
- R6: A request is accepted at an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance through the `fin_pulse` cycle and is 1 in the cycle after that. A request held during a delay waits.
- R7: `fin_pulse` lasts exactly one cycle per accepted request.
- R8: A cycle with `cw_load`=1 stores `cw_word` and `cw_len` (0 is taken as 1 and values above 32 as 32) and sets the bit index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Packet ready to be finalized |
| req_ready | output | 1 | Block can take a finalize request |
| fin_pulse | output | 1 | One-cycle finalize strobe to the network controller |
| win_mode | input | 1 | 0: one bit per packet; 1: runs of ones per packet |
| unit_dly | input | 8 | Unit delay in cycles; 0 disables marking |
| max_run | input | 3 | Largest run per packet in run mode (0 acts as 1) |
| cw_load | input | 1 | Store codeword and length, reset the bit index |
| cw_word | input | 32 | Codeword, bit 0 sent first |
| cw_len | input | 6 | Codeword length n, 1 to 32 |

## Verification
A wrong bit index or run count inside the block shows up at the ports only as a wrong release latency. The bench therefore measures the latency of every packet to the cycle, against a model that tracks the index separately. An index that drifts by a single position shows up within one codeword period. On codewords that are not periodic it usually shows up on the very next packet whose bit differs, and a wrap error shows up on the packet that crosses bit n-1. A counter that is off by one cycle fails the first delayed packet. A handshake fault shows up as `req_ready` being high during a delay or as two strobes for one request.

// File: rtl/prm_pkg.sv
package prm_pkg;

    typedef enum logic [1:0] {
        REL_IDLE = 2'd0,
        REL_WAIT = 2'd1,
        REL_FIRE = 2'd2
    } rel_state_t;

    typedef struct packed {
        logic ready;
        logic fire;
        logic accept;
        logic tmr_start;
    } rel_flags_t;

    function automatic logic [5:0] clamp_len(input logic [5:0] raw, input int unsigned lim);
        logic [5:0] r;
        r = raw;
        if (r == 6'd0) r = 6'd1;
        if (int'(r) > int'(lim)) r = 6'(lim);
        return r;
    endfunction

endpackage

// File: rtl/prm_codeword_ring.sv
module prm_codeword_ring #(
    parameter int CW_MAX = 32,
    parameter int RUN_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ld,
    input  logic [CW_MAX-1:0]           ld_word,
    input  logic [$clog2(CW_MAX+1)-1:0] ld_len,
    input  logic                        burst,
    input  logic [RUN_W-1:0]            run_cap,
    input  logic                        adv_en,
    output logic [RUN_W-1:0]            sig_bits,
    output logic [RUN_W-1:0]            ones
);
    localparam int IDX_W   = $clog2(CW_MAX);
    localparam int LEN_W   = $clog2(CW_MAX+1);
    localparam int RUN_MAX = (1 << RUN_W) - 1;
    localparam int PW      = $clog2(2*CW_MAX + RUN_MAX + 1);

    logic [CW_MAX-1:0] word_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RUN_MAX-1:0] ahead;

    // bits at idx, idx+1, ... read around the ring of length len_q
    for (genvar g = 0; g < RUN_MAX; g++) begin : g_ahead
        logic [PW-1:0] raw_pos;
        logic [PW-1:0] ring_pos;
        assign raw_pos  = PW'(idx_q) + PW'(g);
        assign ring_pos = (raw_pos >= PW'(len_q)) ? raw_pos - PW'(len_q) : raw_pos;
        assign ahead[g] = (ring_pos < PW'(CW_MAX)) ? word_q[IDX_W'(ring_pos)] : 1'b0;
    end

    logic [PW-1:0]    cap;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] eff_cap;
    logic             stop;

    always_comb begin
        eff_cap = (run_cap == '0) ? RUN_W'(1) : run_cap;
        cap     = (PW'(eff_cap) > PW'(len_q)) ? PW'(len_q) : PW'(eff_cap);
        run     = '0;
        stop    = 1'b0;
        for (int j = 0; j < RUN_MAX; j++) begin
            if (!stop && (PW'(j) < cap) && ahead[j]) run = run + 1'b1;
            else stop = 1'b1;
        end
    end

    always_comb begin
        if (!burst) begin
            sig_bits = RUN_W'(1);
            ones     = RUN_W'(ahead[0]);
        end else if (!ahead[0]) begin
            sig_bits = RUN_W'(1);
            ones     = '0;
        end else begin
            sig_bits = run;
            ones     = run;
        end
    end

    logic [PW-1:0] nxt_sum;
    assign nxt_sum = PW'(idx_q) + PW'(sig_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            len_q  <= LEN_W'(1);
            idx_q  <= '0;
        end else if (ld) begin
            word_q <= ld_word;
            len_q  <= prm_pkg::clamp_len(6'(ld_len), CW_MAX);
            idx_q  <= '0;
        end else if (adv_en) begin
            idx_q  <= IDX_W'((nxt_sum >= PW'(len_q)) ? nxt_sum - PW'(len_q) : nxt_sum);
        end
    end

endmodule

// File: rtl/prm_delay_timer.sv
module prm_delay_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= start_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/prm_release_ctrl.sv
module prm_release_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                zero_dly,
    input  logic                tmr_done,
    output prm_pkg::rel_flags_t flags
);
    import prm_pkg::*;

    rel_state_t state_q, state_d;

    always_comb begin
        flags.ready     = (state_q == REL_IDLE);
        flags.fire      = (state_q == REL_FIRE);
        flags.accept    = req_valid && flags.ready;
        flags.tmr_start = flags.accept && !zero_dly;
        state_d         = state_q;
        unique case (state_q)
            REL_IDLE: if (flags.accept) state_d = zero_dly ? REL_FIRE : REL_WAIT;
            REL_WAIT: if (tmr_done)     state_d = REL_FIRE;
            REL_FIRE:                   state_d = REL_IDLE;
            default:                    state_d = REL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= REL_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pkt_release_marker.sv
module pkt_release_marker #(
    parameter int CW_MAX = 32,
    parameter int DLY_W  = 8,
    parameter int RUN_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    output logic                        fin_pulse,
    input  logic                        win_mode,
    input  logic [DLY_W-1:0]            unit_dly,
    input  logic [RUN_W-1:0]            max_run,
    input  logic                        cw_load,
    input  logic [CW_MAX-1:0]           cw_word,
    input  logic [$clog2(CW_MAX+1)-1:0] cw_len
);
    localparam int CNT_W = DLY_W + RUN_W;

    prm_pkg::rel_flags_t flags;
    logic [RUN_W-1:0]    sig_bits;
    logic [RUN_W-1:0]    ones;
    logic [CNT_W-1:0]    total_dly;
    logic                mark_on;
    logic                tmr_done;

    assign mark_on   = (unit_dly != '0);
    assign total_dly = mark_on ? (CNT_W'(ones) * CNT_W'(unit_dly)) : '0;

    prm_codeword_ring #(.CW_MAX(CW_MAX), .RUN_W(RUN_W)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .ld       (cw_load),
        .ld_word  (cw_word),
        .ld_len   (cw_len),
        .burst    (win_mode),
        .run_cap  (max_run),
        .adv_en   (flags.accept && mark_on),
        .sig_bits (sig_bits),
        .ones     (ones)
    );

    prm_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (flags.tmr_start),
        .start_val (total_dly),
        .done      (tmr_done)
    );

    prm_release_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .zero_dly  (total_dly == '0),
        .tmr_done  (tmr_done),
        .flags     (flags)
    );

    assign req_ready = flags.ready;
    assign fin_pulse = flags.fire;

endmodule

// File: rtl/prm_checks.sv
module prm_checks #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             fin_pulse,
    input logic [DLY_W-1:0] unit_dly
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (req_ready && !fin_pulse)); // R1
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R6
    AST_FIN_BUSY: assert property (@(posedge clk) disable iff (rst) fin_pulse |-> !req_ready); // R6
    AST_REOPEN: assert property (@(posedge clk) disable iff (rst) fin_pulse |=> req_ready); // R6
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) fin_pulse |=> !fin_pulse); // R7
    AST_BYPASS_LAT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready && unit_dly == '0) |=> fin_pulse); // R5
endmodule

bind pkt_release_marker prm_checks #(.DLY_W(DLY_W)) u_prm_checks (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .fin_pulse (fin_pulse),
    .unit_dly  (unit_dly)
);

// File: tb/pkt_release_marker_bench.sv
module pkt_release_marker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        fin_pulse;
    logic        win_mode = 1'b0;
    logic [7:0]  unit_dly = '0;
    logic [2:0]  max_run = '0;
    logic        cw_load = 1'b0;
    logic [31:0] cw_word = '0;
    logic [5:0]  cw_len = 6'd1;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    bit [31:0] m_cw = '0;
    int m_n = 1;
    int m_idx = 0;

    always #2 clk = ~clk;

    pkt_release_marker u_pkt_release_marker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .fin_pulse(fin_pulse), .win_mode(win_mode), .unit_dly(unit_dly),
        .max_run(max_run), .cw_load(cw_load), .cw_word(cw_word), .cw_len(cw_len)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(bit [31:0] w, int n);
        @(negedge clk);
        cw_load = 1'b1; cw_word = w; cw_len = 6'(n);
        @(posedge clk);
        #1 cw_load = 1'b0;
        m_cw = w; m_n = n; m_idx = 0;
    endtask

    task automatic send_one(string tag);
        int ones, sig, cap, lat, exp_lat;
        if (unit_dly == 0) begin ones = 0; sig = 0; end
        else if (!win_mode) begin sig = 1; ones = int'(m_cw[m_idx]); end
        else if (!m_cw[m_idx]) begin sig = 1; ones = 0; end
        else begin
            cap = (max_run == 0) ? 1 : int'(max_run);
            if (cap > m_n) cap = m_n;
            ones = 0;
            while (ones < cap && m_cw[(m_idx + ones) % m_n]) ones++;
            sig = ones;
        end
        exp_lat = ones * int'(unit_dly) + 1;
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R6 ready idle"}, int'(req_ready), 1);
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            lat++;
            if (lat == 1) check(req_ready == 1'b0, {tag, " R6 ready low"}, int'(req_ready), 0);
            if (fin_pulse) break;
        end
        check(lat == exp_lat, {tag, " R3 latency"}, lat, exp_lat);
        @(negedge clk);
        check(req_ready == 1'b1 && fin_pulse == 1'b0, {tag, " R7 R6 after fin"},
              int'({req_ready, fin_pulse}), 2);
        m_idx = (m_idx + sig) % m_n;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errs++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        bit [31:0] cws [6];
        int lens [6];
        int f1, f2, cnt;
        cws = '{32'h0000_000B, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 32'hA5C3_F00E, 32'h0000_0076};
        lens = '{4, 1, 2, 3, 32, 8};

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1 && fin_pulse == 1'b0, "R1 in reset", int'({req_ready, fin_pulse}), 2);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && fin_pulse == 1'b0, "R1 after reset", int'({req_ready, fin_pulse}), 2);

        // reset contents: all zeros codeword, length 1
        unit_dly = 8'd3; win_mode = 1'b0;
        send_one("R1");

        for (int c = 0; c < 6; c++) begin
            do_load(cws[c], lens[c]);
            unit_dly = 8'd0; win_mode = 1'b0;
            for (int p = 0; p < 3; p++) send_one("R5");
            for (int d = 1; d <= 3; d++) begin
                unit_dly = 8'(d);
                win_mode = 1'b0;
                for (int p = 0; p < lens[c] + 2; p++) send_one("R2");
                win_mode = 1'b1;
                for (int mr = 0; mr <= 7; mr += (mr == 0) ? 1 : 2) begin
                    max_run = 3'(mr);
                    for (int p = 0; p < lens[c] + 2; p++) send_one("R4");
                end
            end
            // reload in the middle of the stream restarts at bit 0
            unit_dly = 8'd2; win_mode = 1'b0;
            send_one("R8");
            do_load(cws[c], lens[c]);
            for (int p = 0; p < 3; p++) send_one("R8");
        end

        // length clamping: 0 acts as 1, 40 acts as 32
        unit_dly = 8'd2; win_mode = 1'b0;
        do_load(32'h0000_0001, 0);
        m_n = 1;
        for (int p = 0; p < 3; p++) send_one("R8 len0");
        do_load(32'h8000_0001, 40);
        m_n = 32;
        for (int p = 0; p < 34; p++) send_one("R8 len40");

        // request held high across a delay waits for ready
        do_load(32'h0000_000F, 4);
        unit_dly = 8'd3; win_mode = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        cnt = 0; f1 = 0; f2 = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cnt++;
            if (fin_pulse) begin
                if (f1 == 0) f1 = cnt;
                else begin f2 = cnt; req_valid = 1'b0; break; end
            end
        end
        req_valid = 1'b0;
        check(f1 == 4, "R6 held first", f1, 4);
        check(f2 == 9, "R6 held second", f2, 9);
        m_idx = 2;
        send_one("R2 after hold");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule